// File: doc/BRIEF.md
# SDRAM Bank State Protocol Monitor

This block watches an SDRAM command bus without driving anything. On every clock it decodes the chip-select, row-strobe, column-strobe and write-enable lines together with the bank address and address bit 10. It keeps a model of each bank's state: idle, row open, read burst, write burst, write recovery (plain or with auto precharge), precharging, refreshing and mode-register access. Every command is checked against the state of the bank or banks it targets, and against the minimum-spacing windows that must run out first. A command that breaks a rule produces a one-cycle error pulse, an error code and the bank number. An illegal command is treated as never issued, so the model keeps following the legal command stream.

The monitor sits beside a memory controller in simulation or on silicon and flags protocol faults as they happen. Burst length and every timing window are parameters counted in clock cycles. Each bank has its own timers. A single shared timer holds the spacing between activations.

Top module: `sdram_bank_monitor`

## Requirements
- R1: Command decode from {cs_n, ras_n, cas_n, we_n}: cs_n=1 is deselect, 0111 NOP, 0110 burst stop, 0101 READ, 0100 WRITE, 0011 ACTIVE, 0010 PRECHARGE, 0001 REFRESH, 0000 MODE LOAD. Deselect and NOP never raise an error, whatever the other lines carry.
- R2: An illegal command sampled at edge k sets `err` for the cycle after edge k. `err_code` is {command[3:0], bank state[3:0]} and `err_bank` names the bank. Commands are coded NOP=0, BST=1, READ=2, WRITE=3, ACTIVE=4, PRECHARGE=5, REFRESH=6, MODE=7, DESELECT=8. States are coded IDLE=0, ROW=1, READ=2, WRITE=3, WREC=4, WREC_AP=5, PRECH=6, REFR=7, MODE=8.
- R3: An illegal command changes no bank state. `bank_state` holds bank i's state code in bits [4i+3:4i].
- R4: READ or WRITE to a bank fewer than T_RCD cycles after its ACTIVE is illegal.
- R5: PRECHARGE of an open bank fewer than T_RAS cycles after its ACTIVE is illegal. This also applies to precharge-all, which uses A10=1.
- R6: ACTIVE fewer than T_RRD cycles after the last accepted ACTIVE is illegal. ACTIVE to a bank that is not idle is also illegal.
- R7: A READ or WRITE burst lasts BURST_LEN cycles. A read burst then returns the bank to ROW.
- R8: A write burst without auto precharge (A10=0) enters WREC for T_DPL cycles and then goes to ROW. In WREC, READ and WRITE to that bank are legal, and PRECHARGE is illegal.
- R9: A write burst with auto precharge (A10=1) enters WREC_AP for T_DPL cycles and then goes to PRECH. In WREC_AP, READ to that bank is illegal, while ACTIVE to another bank is legal. A burst stop during WREC_AP turns it into WREC, so the bank ends in ROW.
- R10: An accepted REFRESH puts every bank into REFR for T_RC cycles. During that time only NOP, burst stop and deselect are legal.
- R11: An accepted MODE LOAD puts every bank into MODE for 2 cycles. During that time only NOP and deselect are legal; burst stop is flagged.
- R12: PRECH lasts T_RP cycles and then returns to IDLE. When several banks break a precharge-all, the lowest-numbered offending bank is reported and no bank changes.
- R13: REFRESH and MODE LOAD are illegal unless every bank is idle. The reported bank is the lowest one that is not idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Auto precharge / precharge-all flag |
| err | output | 1 | One-cycle illegal-command pulse |
| err_code | output | 8 | {command code, bank state code} |
| err_bank | output | BA_W | Bank the error refers to |
| bank_state | output | 4*BANKS | Current state code of every bank |

## Verification
The hardest case to reach is a command that arrives on the exact edge where a timed state runs out: a burst stop in auto-precharge write recovery, or a read landing in plain write recovery. Both need an activation, a wait of T_RCD, a write burst of BURST_LEN cycles and then a command placed within a window of T_DPL cycles. The directed tasks count edges from a fresh reset so that each command lands on a known cycle of the recovery window. They then sample the state code on the cycles just before and just after the window ends.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

   typedef enum logic [3:0] {
      C_NOP   = 4'd0,
      C_BST   = 4'd1,
      C_READ  = 4'd2,
      C_WRITE = 4'd3,
      C_ACT   = 4'd4,
      C_PRE   = 4'd5,
      C_REF   = 4'd6,
      C_MRS   = 4'd7,
      C_DESL  = 4'd8
   } cmd_e;

   typedef enum logic [3:0] {
      S_IDLE = 4'd0,
      S_ROW  = 4'd1,
      S_RD   = 4'd2,
      S_WR   = 4'd3,
      S_WREC = 4'd4,
      S_WRAP = 4'd5,
      S_PRE  = 4'd6,
      S_REF  = 4'd7,
      S_MODE = 4'd8
   } bst_e;

   localparam int unsigned ST_W      = 4;
   localparam int unsigned MODE_CYC  = 2;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
   import sdram_mon_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd
);

   always_comb begin
      if (cs_n) begin
         cmd = C_DESL;
      end else begin
         unique case ({ras_n, cas_n, we_n})
            3'b111:  cmd = C_NOP;
            3'b110:  cmd = C_BST;
            3'b101:  cmd = C_READ;
            3'b100:  cmd = C_WRITE;
            3'b011:  cmd = C_ACT;
            3'b010:  cmd = C_PRE;
            3'b001:  cmd = C_REF;
            default: cmd = C_MRS;
         endcase
      end
   end

endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
   import sdram_mon_pkg::*;
#(
   parameter int unsigned TW        = 4,
   parameter int unsigned BURST_LEN = 4,
   parameter int unsigned T_DPL     = 2,
   parameter int unsigned T_RP      = 3,
   parameter int unsigned T_RC      = 7,
   parameter int unsigned T_RCD     = 3,
   parameter int unsigned T_RAS     = 6
)(
   input  logic clk,
   input  logic rst_n,
   input  cmd_e cmd,
   input  logic hit,
   input  logic a10,
   input  logic rrd_ok,
   input  logic go,
   output logic illegal,
   output bst_e eff_o,
   output bst_e state_o
);

   localparam int unsigned RCD_W = $clog2(T_RCD + 1);
   localparam int unsigned RAS_W = $clog2(T_RAS + 1);

   bst_e             state_q, eff, nxt_s;
   logic [TW-1:0]    tmr_q, nxt_t;
   logic [RCD_W-1:0] rcd_q;
   logic [RAS_W-1:0] ras_q;
   logic             ap_q, nxt_ap, bad;
   logic             open_row, col_ok;

   function automatic logic [TW-1:0] load_of(input bst_e s);
      case (s)
         S_RD, S_WR:     load_of = TW'(BURST_LEN - 1);
         S_WREC, S_WRAP: load_of = TW'(T_DPL - 1);
         S_PRE:          load_of = TW'(T_RP - 1);
         S_REF:          load_of = TW'(T_RC - 1);
         S_MODE:         load_of = TW'(MODE_CYC - 1);
         default:        load_of = '0;
      endcase
   endfunction

   // state as seen by a command on this edge: a timed state whose timer
   // reached zero has already left
   always_comb begin
      eff = state_q;
      if (tmr_q == '0) begin
         case (state_q)
            S_RD:                eff = ap_q ? S_PRE  : S_ROW;
            S_WR:                eff = ap_q ? S_WRAP : S_WREC;
            S_WREC:              eff = S_ROW;
            S_WRAP:              eff = S_PRE;
            S_PRE, S_REF, S_MODE: eff = S_IDLE;
            default:             eff = state_q;
         endcase
      end
   end

   assign open_row = (eff == S_ROW) || (eff == S_RD) || (eff == S_WR);
   assign col_ok   = (open_row || (eff == S_WREC)) &&
                     !(((eff == S_RD) || (eff == S_WR)) && ap_q) &&
                     (rcd_q == '0);

   always_comb begin
      case (cmd)
         C_BST:           bad = (eff == S_MODE);
         C_READ, C_WRITE: bad = !col_ok;
         C_ACT:           bad = (eff != S_IDLE) || !rrd_ok;
         C_PRE:           bad = (eff == S_WREC) || (eff == S_WRAP) ||
                                (eff == S_REF)  || (eff == S_MODE) ||
                                (open_row && ((ras_q != '0) ||
                                 (((eff == S_RD) || (eff == S_WR)) && ap_q)));
         C_REF, C_MRS:    bad = (eff != S_IDLE);
         default:         bad = 1'b0;
      endcase
   end

   assign illegal = hit && bad;

   always_comb begin
      nxt_s  = eff;
      nxt_ap = ap_q;
      if (eff != state_q)    nxt_t = load_of(eff);
      else if (tmr_q != '0)  nxt_t = tmr_q - TW'(1);
      else                   nxt_t = '0;
      if (go) begin
         case (cmd)
            C_BST: begin
               nxt_ap = 1'b0;
               if (eff == S_RD) begin
                  nxt_s = S_ROW;
                  nxt_t = '0;
               end else if (eff == S_WR) begin
                  nxt_s = S_WREC;
                  nxt_t = load_of(S_WREC);
               end else if (eff == S_WRAP) begin
                  nxt_s = S_WREC;
                  nxt_t = (state_q == S_WRAP) ? tmr_q - TW'(1) : load_of(S_WREC);
               end
            end
            C_READ, C_WRITE: begin
               nxt_s  = (cmd == C_READ) ? S_RD : S_WR;
               nxt_t  = load_of(nxt_s);
               nxt_ap = a10;
            end
            C_ACT: begin
               nxt_s  = S_ROW;
               nxt_t  = '0;
               nxt_ap = 1'b0;
            end
            C_PRE: begin
               if (open_row) begin
                  nxt_s = S_PRE;
                  nxt_t = load_of(S_PRE);
               end
            end
            C_REF, C_MRS: begin
               nxt_s = (cmd == C_REF) ? S_REF : S_MODE;
               nxt_t = load_of(nxt_s);
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         tmr_q   <= '0;
         ap_q    <= 1'b0;
         rcd_q   <= '0;
         ras_q   <= '0;
      end else begin
         state_q <= nxt_s;
         tmr_q   <= nxt_t;
         ap_q    <= nxt_ap;
         if (go && cmd == C_ACT) begin
            rcd_q <= RCD_W'(T_RCD - 1);
            ras_q <= RAS_W'(T_RAS - 1);
         end else begin
            if (rcd_q != '0) rcd_q <= rcd_q - RCD_W'(1);
            if (ras_q != '0) ras_q <= ras_q - RAS_W'(1);
         end
      end
   end

   assign eff_o   = eff;
   assign state_o = state_q;

endmodule

// File: rtl/sdram_bank_monitor.sv
module sdram_bank_monitor
   import sdram_mon_pkg::*;
#(
   parameter int unsigned BANKS     = 4,
   parameter int unsigned BURST_LEN = 4,
   parameter int unsigned T_DPL     = 2,
   parameter int unsigned T_RP      = 3,
   parameter int unsigned T_RC      = 7,
   parameter int unsigned T_RCD     = 3,
   parameter int unsigned T_RAS     = 6,
   parameter int unsigned T_RRD     = 2,
   localparam int unsigned BA_W     = $clog2(BANKS)
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cs_n,
   input  logic                  ras_n,
   input  logic                  cas_n,
   input  logic                  we_n,
   input  logic [BA_W-1:0]       ba,
   input  logic                  a10,
   output logic                  err,
   output logic [7:0]            err_code,
   output logic [BA_W-1:0]       err_bank,
   output logic [ST_W*BANKS-1:0] bank_state
);

   function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   localparam int unsigned T_MAX = max_of(max_of(BURST_LEN, T_DPL),
                                          max_of(max_of(T_RP, T_RC), MODE_CYC));
   localparam int unsigned TW    = $clog2(T_MAX + 1);
   localparam int unsigned RRD_W = $clog2(T_RRD + 1);

   generate
      if (BANKS < 2 || (BANKS & (BANKS - 1)) != 0) begin : g_bad_banks
         $error("BANKS must be a power of two of at least 2");
      end
      if (BURST_LEN < 1 || T_DPL < 1 || T_RP < 1 || T_RC < 1 ||
          T_RCD < 1 || T_RAS < 1 || T_RRD < 1) begin : g_bad_timing
         $error("burst length and timing windows must be at least 1 cycle");
      end
   endgenerate

   cmd_e              cmd;
   logic [BANKS-1:0]  hit, bad, go;
   bst_e              eff [BANKS];
   bst_e              st  [BANKS];
   logic              any_bad, rrd_ok;
   logic [RRD_W-1:0]  rrd_q;
   logic [BA_W-1:0]   sel_bank;
   bst_e              sel_state;

   sdram_cmd_decode u_dec (
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .cmd   (cmd)
   );

   assign any_bad = |bad;
   assign rrd_ok  = (rrd_q == '0);

   for (genvar gi = 0; gi < BANKS; gi++) begin : g_bank
      always_comb begin
         case (cmd)
            C_BST, C_REF, C_MRS:    hit[gi] = 1'b1;
            C_READ, C_WRITE, C_ACT: hit[gi] = (ba == BA_W'(gi));
            C_PRE:                  hit[gi] = a10 || (ba == BA_W'(gi));
            default:                hit[gi] = 1'b0;
         endcase
      end
      assign go[gi] = hit[gi] && !any_bad;

      sdram_bank_track #(
         .TW        (TW),
         .BURST_LEN (BURST_LEN),
         .T_DPL     (T_DPL),
         .T_RP      (T_RP),
         .T_RC      (T_RC),
         .T_RCD     (T_RCD),
         .T_RAS     (T_RAS)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .cmd     (cmd),
         .hit     (hit[gi]),
         .a10     (a10),
         .rrd_ok  (rrd_ok),
         .go      (go[gi]),
         .illegal (bad[gi]),
         .eff_o   (eff[gi]),
         .state_o (st[gi])
      );

      assign bank_state[gi*ST_W +: ST_W] = st[gi];
   end

   // lowest-numbered offending bank wins
   always_comb begin
      sel_bank  = '0;
      sel_state = S_IDLE;
      for (int i = BANKS - 1; i >= 0; i--) begin
         if (bad[i]) begin
            sel_bank  = BA_W'(i);
            sel_state = eff[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rrd_q    <= '0;
         err      <= 1'b0;
         err_code <= '0;
         err_bank <= '0;
      end else begin
         if (cmd == C_ACT && !any_bad) rrd_q <= RRD_W'(T_RRD - 1);
         else if (rrd_q != '0)         rrd_q <= rrd_q - RRD_W'(1);
         err <= any_bad;
         if (any_bad) begin
            err_code <= {cmd, sel_state};
            err_bank <= sel_bank;
         end
      end
   end

endmodule

// File: rtl/sdram_bank_monitor_chk.sv
module sdram_bank_monitor_chk
   import sdram_mon_pkg::*;
#(
   parameter int unsigned BANKS = 4,
   localparam int unsigned BA_W = $clog2(BANKS)
)(
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cs_n,
   input logic                  ras_n,
   input logic                  cas_n,
   input logic                  we_n,
   input logic [BA_W-1:0]       ba,
   input logic                  a10,
   input logic                  err,
   input logic [7:0]            err_code,
   input logic [BA_W-1:0]       err_bank,
   input logic [ST_W*BANKS-1:0] bank_state
);

   localparam logic [ST_W*BANKS-1:0] ALL_REF  = {BANKS{S_REF}};
   localparam logic [ST_W*BANKS-1:0] ALL_MODE = {BANKS{S_MODE}};

   logic quiet, is_ref, is_mrs;
   assign quiet  = cs_n || (ras_n && cas_n && we_n);
   assign is_ref = !cs_n && !ras_n && !cas_n && we_n;
   assign is_mrs = !cs_n && !ras_n && !cas_n && !we_n;

   AST_QUIET_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      quiet |=> !err);                                                   // R1
   AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !$past(quiet));                                            // R2
   AST_REF_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
      is_ref |=> (err || bank_state == ALL_REF));                        // R10
   AST_MRS_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
      is_mrs |=> (err || bank_state == ALL_MODE));                       // R11

   for (genvar g = 0; g < BANKS; g++) begin : g_bank_chk
      AST_MODE_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
         (bank_state[g*ST_W +: ST_W] == S_MODE &&
          $past(bank_state[g*ST_W +: ST_W]) == S_MODE)
         |=> bank_state[g*ST_W +: ST_W] != S_MODE);                      // R11
      AST_WRITE_NEEDS_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
         bank_state[g*ST_W +: ST_W] == S_WR
         |=> bank_state[g*ST_W +: ST_W] != S_ROW);                       // R8
   end

endmodule

bind sdram_bank_monitor sdram_bank_monitor_chk #(.BANKS(BANKS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_n       (cs_n),
   .ras_n      (ras_n),
   .cas_n      (cas_n),
   .we_n       (we_n),
   .ba         (ba),
   .a10        (a10),
   .err        (err),
   .err_code   (err_code),
   .err_bank   (err_bank),
   .bank_state (bank_state)
);

// File: tb/sdram_bank_monitor_test.sv
module sdram_bank_monitor_test;
   import sdram_mon_pkg::*;

   localparam int BANKS = 4;
   localparam int BA_W  = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [BA_W-1:0] ba = '0;
   logic            a10 = 1'b0;
   logic            err;
   logic [7:0]      err_code;
   logic [BA_W-1:0] err_bank;
   logic [15:0]     bank_state;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10ns clk = ~clk;

   sdram_bank_monitor #(.BANKS(BANKS)) uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .ba(ba), .a10(a10), .err(err), .err_code(err_code),
      .err_bank(err_bank), .bank_state(bank_state)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_err(input string req, input bit e, input logic [7:0] code, input int b);
      if (e) check(req, {23'd0, err, err_code}, {23'd0, 1'b1, code});
      else   check(req, {31'd0, err}, 32'd0);
      if (e) check(req, {30'd0, err_bank}, b);
   endtask

   task automatic put_nop();
      cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; a10 = 1'b0; ba = '0;
   endtask

   // drive at a falling edge, sampled by the next rising edge
   task automatic send(input cmd_e c, input int b, input bit a);
      cs_n = (c == C_DESL);
      case (c)
         C_NOP:   {ras_n, cas_n, we_n} = 3'b111;
         C_BST:   {ras_n, cas_n, we_n} = 3'b110;
         C_READ:  {ras_n, cas_n, we_n} = 3'b101;
         C_WRITE: {ras_n, cas_n, we_n} = 3'b100;
         C_ACT:   {ras_n, cas_n, we_n} = 3'b011;
         C_PRE:   {ras_n, cas_n, we_n} = 3'b010;
         C_REF:   {ras_n, cas_n, we_n} = 3'b001;
         default: {ras_n, cas_n, we_n} = 3'b000;
      endcase
      ba  = BA_W'(b);
      a10 = a;
      @(negedge clk);
      put_nop();
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      put_nop();
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
   endtask

   task automatic t_reset_state();
      do_reset();
      check("R2 reset err", {31'd0, err}, 32'd0);
      check("R3 reset states", {16'd0, bank_state}, 32'h0000);
   endtask

   task automatic t_rcd_and_burst();
      do_reset();
      send(C_ACT, 0, 0);
      check("R6 act opens row", {16'd0, bank_state}, 32'h0001);
      send(C_READ, 0, 0);
      check_err("R4 read before trcd", 1, 8'h21, 0);
      check("R3 illegal read ignored", {16'd0, bank_state}, 32'h0001);
      cs_n = 1'b1; ras_n = 1'b0; cas_n = 1'b0; we_n = 1'b0;
      @(negedge clk);
      put_nop();
      check_err("R1 deselect ignored", 0, 8'h00, 0);
      send(C_READ, 0, 0);
      check_err("R4 read after trcd", 0, 8'h00, 0);
      check("R7 read burst", {16'd0, bank_state}, 32'h0002);
      idle(3);
      check("R7 burst still running", {16'd0, bank_state}, 32'h0002);
      idle(1);
      check("R7 burst back to row", {16'd0, bank_state}, 32'h0001);
   endtask

   task automatic t_rrd_ras_rp();
      do_reset();
      send(C_ACT, 1, 0);
      send(C_ACT, 2, 0);
      check_err("R6 act inside trrd", 1, 8'h40, 2);
      send(C_ACT, 2, 0);
      check_err("R6 act after trrd", 0, 8'h00, 0);
      check("R6 two rows open", {16'd0, bank_state}, 32'h0110);
      send(C_PRE, 1, 0);
      check_err("R5 pre inside tras", 1, 8'h51, 1);
      check("R3 illegal pre ignored", {16'd0, bank_state}, 32'h0110);
      idle(2);
      send(C_PRE, 1, 0);
      check_err("R5 pre after tras", 0, 8'h00, 0);
      check("R12 precharging", {16'd0, bank_state}, 32'h0160);
      idle(2);
      check("R12 still precharging", {16'd0, bank_state}, 32'h0160);
      idle(1);
      check("R12 back to idle", {16'd0, bank_state}, 32'h0100);
   endtask

   task automatic t_write_recovery();
      do_reset();
      send(C_ACT, 0, 0);
      idle(2);
      send(C_WRITE, 0, 0);
      idle(3);
      check("R8 write burst", {16'd0, bank_state}, 32'h0003);
      idle(1);
      check("R8 in recovery", {16'd0, bank_state}, 32'h0004);
      send(C_PRE, 0, 0);
      check_err("R8 pre during recovery", 1, 8'h54, 0);
      idle(1);
      check("R8 recovery to row", {16'd0, bank_state}, 32'h0001);
      send(C_WRITE, 0, 0);
      idle(4);
      check("R8 second recovery", {16'd0, bank_state}, 32'h0004);
      send(C_READ, 0, 0);
      check_err("R8 read during recovery", 0, 8'h00, 0);
      check("R8 read accepted", {16'd0, bank_state}, 32'h0002);
   endtask

   task automatic t_write_recovery_ap();
      do_reset();
      send(C_ACT, 0, 0);
      idle(2);
      send(C_WRITE, 0, 1);
      idle(4);
      check("R9 ap recovery", {16'd0, bank_state}, 32'h0005);
      send(C_READ, 0, 0);
      check_err("R9 read during ap recovery", 1, 8'h25, 0);
      send(C_ACT, 1, 0);
      check_err("R9 act other bank", 0, 8'h00, 0);
      check("R9 ap recovery to precharge", {16'd0, bank_state}, 32'h0016);
   endtask

   task automatic t_bst_in_ap_recovery();
      do_reset();
      send(C_ACT, 0, 0);
      idle(2);
      send(C_WRITE, 0, 1);
      idle(4);
      send(C_BST, 0, 0);
      check_err("R9 bst legal in ap recovery", 0, 8'h00, 0);
      check("R9 bst drops auto precharge", {16'd0, bank_state}, 32'h0004);
      idle(1);
      check("R9 bst ends in row", {16'd0, bank_state}, 32'h0001);
   endtask

   task automatic t_refresh();
      do_reset();
      send(C_REF, 0, 0);
      check_err("R10 refresh accepted", 0, 8'h00, 0);
      check("R10 all refreshing", {16'd0, bank_state}, 32'h7777);
      send(C_READ, 2, 0);
      check_err("R10 read during refresh", 1, 8'h27, 2);
      send(C_BST, 0, 0);
      check_err("R10 bst during refresh", 0, 8'h00, 0);
      idle(4);
      check("R10 refresh holds", {16'd0, bank_state}, 32'h7777);
      idle(1);
      check("R10 refresh done", {16'd0, bank_state}, 32'h0000);
   endtask

   task automatic t_mode_and_global();
      do_reset();
      send(C_MRS, 0, 0);
      check("R11 all in mode", {16'd0, bank_state}, 32'h8888);
      send(C_BST, 0, 0);
      check_err("R11 bst during mode", 1, 8'h18, 0);
      idle(1);
      check("R11 mode done", {16'd0, bank_state}, 32'h0000);
      send(C_ACT, 3, 0);
      check("R13 bank3 open", {16'd0, bank_state}, 32'h1000);
      send(C_REF, 0, 0);
      check_err("R13 refresh with open bank", 1, 8'h61, 3);
      check("R13 refresh ignored", {16'd0, bank_state}, 32'h1000);
      send(C_MRS, 0, 0);
      check_err("R13 mode with open bank", 1, 8'h71, 3);
   endtask

   task automatic t_precharge_all();
      do_reset();
      send(C_ACT, 0, 0);
      idle(1);
      send(C_ACT, 1, 0);
      idle(3);
      send(C_PRE, 0, 1);
      check_err("R12 pall inside tras", 1, 8'h51, 1);
      check("R12 pall ignored", {16'd0, bank_state}, 32'h0011);
      idle(1);
      send(C_PRE, 0, 1);
      check_err("R5 pall after tras", 0, 8'h00, 0);
      check("R12 pall precharges", {16'd0, bank_state}, 32'h0066);
   endtask

   initial begin
      put_nop();
      @(negedge clk);
      t_reset_state();
      t_rcd_and_burst();
      t_rrd_ras_rp();
      t_write_recovery();
      t_write_recovery_ap();
      t_bst_in_ap_recovery();
      t_refresh();
      t_mode_and_global();
      t_precharge_all();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule